// File: doc/BRIEF.md
# Dual-Priority Interrupt Controller

The block gathers 32 level-sensitive interrupt inputs into one registered source word and routes every input to two request classes: a normal class and a fast class. Each class has its own enable mask, and the masked result is shown as a read-only pending word. A class raises its request line to the processor while any of its pending bits is set. The three lowest source bits always read as asserted. Software can therefore raise an interrupt of either class by setting one of those bits in the matching enable mask.

Software reaches the five registers over a simple single-cycle register bus. The bus carries a request strobe, write enable, byte address, 32-bit write data, an access-size code and a supervisor flag. The response (read data and a bus-error flag) is registered and appears in the cycle after the request. Only supervisor-mode, aligned, full-word accesses to a mapped register are accepted. Any other access is refused with an error and changes nothing.

Top module: `irqc_top`

## Requirements
- R1: Offset 0x00 reads the source word, which is src_i captured on the previous clock edge with bits 0, 1 and 2 forced to 1.
- R2: Offset 0x04 is the normal enable mask: it is read/write, its write takes effect at the request's clock edge, and it resets to 0.
- R3: Offset 0x08 is the fast enable mask, with the same read/write and reset behaviour as the normal mask.
- R4: Offset 0x0C reads source AND normal mask, and offset 0x10 reads source AND fast mask.
- R5: irq_norm_o is high exactly when some normal pending bit is set, and irq_fast_o is high exactly when some fast pending bit is set.
- R6: An access with sup_i=0 returns err_o=1 with rdata_o=0 and leaves both masks unchanged.
- R7: An access whose size_i is not 2'b10 (word; 2'b00 byte and 2'b01 half) returns err_o=1 and leaves both masks unchanged.
- R8: A write to offset 0x00, 0x0C or 0x10 returns err_o=1 and changes no state.
- R9: An address with addr_i[1:0] not 0, or with a word index of 5 or higher, returns err_o=1.
- R10: After reset both request lines are low and both masks read 0, even though source bits 0 to 2 read 1.
- R11: rdata_o and err_o are valid in the cycle after the request. A write that is accepted returns rdata_o=0 and err_o=0, and both outputs are 0 in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt inputs, 1 = asserted |
| req_i | input | 1 | Bus request strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address within the block |
| size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| sup_i | input | 1 | 1 = supervisor-mode access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Bus error, one cycle after the request |
| irq_norm_o | output | 1 | Normal-class interrupt request |
| irq_fast_o | output | 1 | Fast-class interrupt request |

## Verification
The assertions assume that req_i, we_i, addr_i, size_i, sup_i and wdata_i are stable around each rising edge and are low or idle during reset. They also assume that src_i is a level input that needs no synchronizer. The bench changes every input only on the falling clock edge and holds req_i low while reset is applied. It also lets one cycle pass after each src_i change before it reads a source-derived value, so every read sees a settled source word.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned N_SRC  = 32;
  localparam int unsigned N_TIED = 3;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [2:0] {
    REG_SRC  = 3'd0,
    REG_NEN  = 3'd1,
    REG_FEN  = 3'd2,
    REG_NPND = 3'd3,
    REG_FPND = 3'd4,
    REG_NONE = 3'd7
  } reg_e;
endpackage

// File: rtl/irqc_src_reg.sv
module irqc_src_reg #(
  parameter int unsigned N      = 32,
  parameter int unsigned N_TIED = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] src_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < N_TIED) begin : g_tied
      assign src_o[i] = 1'b1;
    end else begin : g_flop
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= src_i[i];
      end
      assign src_o[i] = q;
    end
  end
endmodule

// File: rtl/irqc_bus_dec.sv
module irqc_bus_dec
  import irqc_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          sup_i,
  output reg_e          sel_o,
  output logic          err_o,
  output logic          wr_nen_o,
  output logic          wr_fen_o
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          aligned, ro_sel, bad;

  assign idx     = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    unique case (idx)
      IW'(0):  sel_o = REG_SRC;
      IW'(1):  sel_o = REG_NEN;
      IW'(2):  sel_o = REG_FEN;
      IW'(3):  sel_o = REG_NPND;
      IW'(4):  sel_o = REG_FPND;
      default: sel_o = REG_NONE;
    endcase
  end

  assign ro_sel = (sel_o == REG_SRC) || (sel_o == REG_NPND) || (sel_o == REG_FPND);
  assign bad    = !sup_i || (size_i != SZ_WORD) || !aligned ||
                  (sel_o == REG_NONE) || (we_i && ro_sel);

  assign err_o    = req_i && bad;
  assign wr_nen_o = req_i && !bad && we_i && (sel_o == REG_NEN);
  assign wr_fen_o = req_i && !bad && we_i && (sel_o == REG_FEN);
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int unsigned N     = 32,
  parameter int unsigned N_CLS = 2
) (
  input  logic [N-1:0]            src_i,
  input  logic [N_CLS-1:0][N-1:0] en_i,
  output logic [N_CLS-1:0][N-1:0] pend_o,
  output logic [N_CLS-1:0]        irq_o
);
  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    assign pend_o[c] = src_i & en_i[c];
    assign irq_o[c]  = |pend_o[c];
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N  = N_SRC,
  parameter int unsigned NT = N_TIED,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          sup_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic          err_o,
  output logic          irq_norm_o,
  output logic          irq_fast_o
);
  localparam int unsigned C_NRM = 0;
  localparam int unsigned C_FST = 1;

  logic [N-1:0]       src_q, nen_q, fen_q, rd_mux;
  logic [1:0][N-1:0]  en_v, pend_v;
  logic [1:0]         irq_v;
  reg_e               sel;
  logic               dec_err, wr_nen, wr_fen;

  irqc_src_reg #(.N(N), .N_TIED(NT)) u_src (
    .clk_i, .rst_ni, .src_i, .src_o(src_q)
  );

  irqc_bus_dec #(.AW(AW)) u_dec (
    .req_i, .we_i, .addr_i, .size_i, .sup_i,
    .sel_o(sel), .err_o(dec_err), .wr_nen_o(wr_nen), .wr_fen_o(wr_fen)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nen_q <= '0;
      fen_q <= '0;
    end else begin
      if (wr_nen) nen_q <= wdata_i;
      if (wr_fen) fen_q <= wdata_i;
    end
  end

  assign en_v[C_NRM] = nen_q;
  assign en_v[C_FST] = fen_q;

  irqc_pend #(.N(N), .N_CLS(2)) u_pend (
    .src_i(src_q), .en_i(en_v), .pend_o(pend_v), .irq_o(irq_v)
  );

  assign irq_norm_o = irq_v[C_NRM];
  assign irq_fast_o = irq_v[C_FST];

  always_comb begin
    unique case (sel)
      REG_SRC:  rd_mux = src_q;
      REG_NEN:  rd_mux = nen_q;
      REG_FEN:  rd_mux = fen_q;
      REG_NPND: rd_mux = pend_v[C_NRM];
      REG_FPND: rd_mux = pend_v[C_FST];
      default:  rd_mux = '0;
    endcase
  end

  // response registered; accepted writes and errors return zero data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o   <= dec_err;
      rdata_o <= (req_i && !dec_err && !we_i) ? rd_mux : '0;
    end
  end

  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && dec_err) |=> ($stable(nen_q) && $stable(fen_q))); // R6
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0)); // R6
  AST_SIZE_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != SZ_WORD) |=> err_o); // R7
  AST_RO_WRITE_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[AW-1:2] == 0 || addr_i[AW-1:2] == 3 ||
     addr_i[AW-1:2] == 4)) |=> err_o); // R8
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || rdata_o != '0) |-> $past(req_i)); // R11
  AST_NORM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_norm_o |-> (nen_q != '0)); // R5
  AST_FAST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fast_o |-> (fen_q != '0)); // R5
  AST_NEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_nen |=> (nen_q == $past(wdata_i))); // R2
  AST_FEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fen |=> (fen_q == $past(wdata_i))); // R3
endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  localparam int unsigned N = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [4:0]    addr_i = '0;
  logic [1:0]    size_i = 2'b10;
  logic          sup_i = 1'b1;
  logic [N-1:0]  wdata_i = '0;
  logic [N-1:0]  rdata_o;
  logic          err_o, irq_norm_o, irq_fast_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [N-1:0] exp_d[$];
  bit           exp_e[$];
  string        exp_t[$];
  logic         seen = 1'b0;

  logic [N-1:0] src_m = 32'h7;
  logic [N-1:0] nen_m = '0;
  logic [N-1:0] fen_m = '0;

  always #10 clk_i = ~clk_i;

  irqc_top dut_i (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .size_i, .sup_i,
    .wdata_i, .rdata_o, .err_o, .irq_norm_o, .irq_fast_o
  );

  always @(posedge clk_i) seen <= req_i;

  // monitor: compare the response in the cycle after each request
  always @(negedge clk_i) begin
    if (seen) begin
      logic [N-1:0] d; bit e; string t;
      d = exp_d.pop_front(); e = exp_e.pop_front(); t = exp_t.pop_front();
      total++;
      if (rdata_o !== d || err_o !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 t, rdata_o, err_o, d, e);
      end
    end
  end

  task automatic access(input bit we, input logic [4:0] a, input logic [1:0] sz,
                        input bit sup, input logic [N-1:0] wd,
                        input logic [N-1:0] ed, input bit ee, input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; sup_i = sup; wdata_i = wd;
    exp_d.push_back(ed); exp_e.push_back(ee); exp_t.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; sup_i = 1'b1; size_i = 2'b10;
  endtask

  task automatic rd_ok(input logic [4:0] a, input logic [N-1:0] ed, input string tag);
    access(1'b0, a, 2'b10, 1'b1, '0, ed, 1'b0, tag);
  endtask

  task automatic wr_ok(input logic [4:0] a, input logic [N-1:0] wd, input string tag);
    access(1'b1, a, 2'b10, 1'b1, wd, '0, 1'b0, tag);
    if (a == 5'h04) nen_m = wd;
    if (a == 5'h08) fen_m = wd;
  endtask

  task automatic chk_irq(input string tag);
    total++;
    if (irq_norm_o !== |(src_m & nen_m) || irq_fast_o !== |(src_m & fen_m)) begin
      bad++;
      $display("FAIL %s: irq n/f=%b%b expected %b%b", tag, irq_norm_o, irq_fast_o,
               |(src_m & nen_m), |(src_m & fen_m));
    end
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(negedge clk_i);
    src_i = v;
    src_m = v | 32'h7;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk_irq("R10 irq after reset");
    rd_ok(5'h04, 32'h0, "R10 R2 nen reset");
    rd_ok(5'h08, 32'h0, "R10 R3 fen reset");
    rd_ok(5'h00, 32'h7, "R1 tied bits after reset");
    // R11 idle response
    @(negedge clk_i);
    total++;
    if (err_o !== 1'b0 || rdata_o !== '0) begin
      bad++;
      $display("FAIL R11 idle: rdata=%h err=%b expected 0 0", rdata_o, err_o);
    end

    set_src(32'hA5A5_0000);
    rd_ok(5'h00, 32'hA5A5_0007, "R1 source word");
    wr_ok(5'h04, 32'h0000_0001, "R2 nen write");
    chk_irq("R5 soft irq via tied bit");
    rd_ok(5'h04, 32'h0000_0001, "R2 nen readback");
    rd_ok(5'h0C, 32'h0000_0001, "R4 normal pending");
    wr_ok(5'h08, 32'h00F0_0000, "R3 fen write");
    chk_irq("R5 fast irq");
    rd_ok(5'h08, 32'h00F0_0000, "R3 fen readback");
    rd_ok(5'h10, 32'h00A0_0000, "R4 fast pending");

    // R6 user mode
    access(1'b1, 5'h04, 2'b10, 1'b0, 32'hFFFF_FFFF, '0, 1'b1, "R6 user write");
    access(1'b0, 5'h00, 2'b10, 1'b0, '0, '0, 1'b1, "R6 user read");
    rd_ok(5'h04, 32'h0000_0001, "R6 nen unchanged");
    // R7 size
    access(1'b1, 5'h08, 2'b01, 1'b1, 32'h0000_00FF, '0, 1'b1, "R7 half write");
    access(1'b0, 5'h00, 2'b00, 1'b1, '0, '0, 1'b1, "R7 byte read");
    rd_ok(5'h08, 32'h00F0_0000, "R7 fen unchanged");
    // R8 read-only writes
    access(1'b1, 5'h00, 2'b10, 1'b1, 32'h0, '0, 1'b1, "R8 write source");
    access(1'b1, 5'h0C, 2'b10, 1'b1, 32'h0, '0, 1'b1, "R8 write npend");
    access(1'b1, 5'h10, 2'b10, 1'b1, 32'h0, '0, 1'b1, "R8 write fpend");
    rd_ok(5'h04, 32'h0000_0001, "R8 nen unchanged");
    rd_ok(5'h08, 32'h00F0_0000, "R8 fen unchanged");
    chk_irq("R8 irq unchanged");
    // R9 address
    access(1'b0, 5'h14, 2'b10, 1'b1, '0, '0, 1'b1, "R9 unmapped 0x14");
    access(1'b0, 5'h1C, 2'b10, 1'b1, '0, '0, 1'b1, "R9 unmapped 0x1C");
    access(1'b0, 5'h06, 2'b10, 1'b1, '0, '0, 1'b1, "R9 misaligned");

    // source withdrawn, fast drops, normal holds via tied bit
    set_src(32'h0);
    chk_irq("R5 fast drops with source");
    rd_ok(5'h10, 32'h0, "R4 fast pending clear");
    wr_ok(5'h04, 32'h0, "R2 nen clear");
    chk_irq("R5 normal drops with mask");
    wr_ok(5'h08, 32'h0000_0006, "R3 fen tied bits");
    chk_irq("R5 fast via tied bits");
    rd_ok(5'h10, 32'h0000_0006, "R4 fast pending tied");

    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule